// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with APB Register Port

The block gathers a configurable number of level-sensitive interrupt lines, from 2 to 64, and folds them into one interrupt request for a processor or a parent controller. Software reaches it over an APB slave port. Each source has an enable bit and a mask bit, and both are stored in two 32-bit words: sources 0 to 31 sit in the low word and sources 32 and up sit in the high word. A pair of read-only words reports which sources are pending at this moment. A source is pending when its line is high, it is enabled and it is not masked.

Enable and mask flip-flops exist only for implemented sources. Software can find the source count by writing all ones to the enable words and reading them back. The source lines are registered once before use. The combined request is the registered OR of every pending bit.

An APB phase tracker with three named states checks that each access has a valid setup phase. ST_IDLE moves to ST_SETUP when psel is high and penable is low. ST_SETUP moves to ST_ACCESS when psel and penable are both high; the transfer completes in that cycle. ST_SETUP stays in ST_SETUP on another setup cycle, and returns to ST_IDLE otherwise. ST_ACCESS goes to ST_SETUP on a back-to-back setup cycle, and returns to ST_IDLE otherwise.

Top module: `apb_irq_ctrl`

## Requirements
- R1: After reset, every enable and mask bit is 0, every pending-status bit is 0 and irq_out is low.
- R2: Enable words sit at offsets 0x00 (sources 0-31) and 0x04 (sources 32-63). Mask words sit at 0x08 (low) and 0x0C (high). Source n is bit n mod 32 of its word. Bits for sources at or above NUM_SRC are not stored and read as 0, so the high words read 0 whenever NUM_SRC is 32 or less.
- R3: A mask bit of 1 blocks its source from status and from irq_out. A mask bit of 0 lets the source through.
- R4: Pending status is read at 0x30 (sources 0-31) and 0x34 (sources 32-63). Bit n equals the value of source line n one clock earlier, ANDed with enable n and with the inverse of mask n. A bit clears as soon as its registered line falls.
- R5: irq_out goes high one clock after any pending bit is 1, and goes low one clock after all pending bits are 0.
- R6: The status words are read-only. A write to 0x30 or 0x34 changes no enable or mask bit.
- R7: An offset other than the six listed reads as 0, and a write to it changes no enable or mask bit.
- R8: pready is always 1 and pslverr is always 0.
- R9: A write takes effect only in an access cycle (psel and penable both high) that follows a setup cycle (psel high, penable low). A cycle with psel high and penable high but no setup cycle before it is ignored. No register changes in a cycle where psel is low.
- R10: Read data is valid in the access cycle and reflects the register state at the start of that cycle. prdata is 0 outside read access cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer ready, always 1 |
| pslverr | output | 1 | Transfer error, always 0 |
| irq_src | input | NUM_SRC | Level-sensitive interrupt lines |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Two events can fall on the same clock edge: a bus write that completes and changes an enable or mask bit, and a change on a source line. The bench provokes this on purpose. It raises a source line at the same clock edge where a write that enables that same source completes. It also does the reverse: a mask write lands on the edge where a pending source drops. A behavioural model updates its enable, mask and registered-source state on each edge. The model predicts irq_out on every clock and predicts the status read that follows. This checks that the pending bit appears, or disappears, in the cycle that the registered source and the new register value give together.

// File: rtl/ictl_pkg.sv
package ictl_pkg;

    // APB phase tracker states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } apb_state_e;

    // decoded register selection
    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_EN_LO = 3'd1,
        SEL_EN_HI = 3'd2,
        SEL_MK_LO = 3'd3,
        SEL_MK_HI = 3'd4,
        SEL_ST_LO = 3'd5,
        SEL_ST_HI = 3'd6
    } reg_sel_e;

    localparam int OFS_EN_LO = 'h00;
    localparam int OFS_EN_HI = 'h04;
    localparam int OFS_MK_LO = 'h08;
    localparam int OFS_MK_HI = 'h0C;
    localparam int OFS_ST_LO = 'h30;
    localparam int OFS_ST_HI = 'h34;

    localparam int WORD_W  = 32;
    localparam int MAX_SRC = 64;

endpackage

// File: rtl/ictl_apb_fsm.sv
module ictl_apb_fsm
    import ictl_pkg::*;
(
    input  logic pclk,
    input  logic presetn,
    input  logic psel,
    input  logic penable,
    output logic xfer
);

    apb_state_e state_q;
    apb_state_e state_d;

    // state register
    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                state_d = (psel && !penable) ? ST_SETUP : ST_IDLE;
            end
            ST_SETUP: begin
                if (psel && penable) begin
                    state_d = ST_ACCESS;
                end else if (psel && !penable) begin
                    state_d = ST_SETUP;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_ACCESS: begin
                state_d = (psel && !penable) ? ST_SETUP : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // output logic: a transfer completes in the access cycle after a setup
    always_comb begin
        xfer = (state_q == ST_SETUP) && psel && penable;
    end

endmodule

// File: rtl/ictl_regs.sv
module ictl_regs
    import ictl_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic                pclk,
    input  logic                presetn,
    input  logic                wr_en,
    input  reg_sel_e            sel,
    input  logic [WORD_W-1:0]   wdata,
    output logic [MAX_SRC-1:0]  en_w,
    output logic [MAX_SRC-1:0]  mk_w
);

    for (genvar i = 0; i < MAX_SRC; i++) begin : g_bit
        if (i < NUM_SRC) begin : g_impl
            localparam reg_sel_e EN_SEL = (i < WORD_W) ? SEL_EN_LO : SEL_EN_HI;
            localparam reg_sel_e MK_SEL = (i < WORD_W) ? SEL_MK_LO : SEL_MK_HI;
            logic en_q;
            logic mk_q;

            always_ff @(posedge pclk or negedge presetn) begin
                if (!presetn) begin
                    en_q <= 1'b0;
                    mk_q <= 1'b0;
                end else if (wr_en) begin
                    if (sel == EN_SEL) begin
                        en_q <= wdata[i % WORD_W];
                    end
                    if (sel == MK_SEL) begin
                        mk_q <= wdata[i % WORD_W];
                    end
                end
            end

            assign en_w[i] = en_q;
            assign mk_w[i] = mk_q;
        end else begin : g_trim
            assign en_w[i] = 1'b0;
            assign mk_w[i] = 1'b0;
        end
    end

endmodule

// File: rtl/ictl_status.sv
module ictl_status
    import ictl_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic [NUM_SRC-1:0] src,
    input  logic [MAX_SRC-1:0] en_w,
    input  logic [MAX_SRC-1:0] mk_w,
    output logic [MAX_SRC-1:0] fstat_w,
    output logic               irq
);

    logic [NUM_SRC-1:0] src_q;
    logic [MAX_SRC-1:0] src_w;
    logic               irq_q;

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            src_q <= '0;
            irq_q <= 1'b0;
        end else begin
            src_q <= src;
            irq_q <= |fstat_w;
        end
    end

    assign src_w   = MAX_SRC'(src_q);
    assign fstat_w = src_w & en_w & ~mk_w;
    assign irq     = irq_q;

endmodule

// File: rtl/apb_irq_ctrl.sv
module apb_irq_ctrl
    import ictl_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int ADDR_W  = 8
) (
    input  logic                pclk,
    input  logic                presetn,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [31:0]         pwdata,
    output logic [31:0]         prdata,
    output logic                pready,
    output logic                pslverr,
    input  logic [NUM_SRC-1:0]  irq_src,
    output logic                irq_out
);

    logic               xfer;
    reg_sel_e           sel;
    logic [MAX_SRC-1:0] en_w;
    logic [MAX_SRC-1:0] mk_w;
    logic [MAX_SRC-1:0] fstat_w;

    ictl_apb_fsm u_fsm (
        .pclk    (pclk),
        .presetn (presetn),
        .psel    (psel),
        .penable (penable),
        .xfer    (xfer)
    );

    // offset decode
    always_comb begin
        if (paddr == ADDR_W'(OFS_EN_LO))      sel = SEL_EN_LO;
        else if (paddr == ADDR_W'(OFS_EN_HI)) sel = SEL_EN_HI;
        else if (paddr == ADDR_W'(OFS_MK_LO)) sel = SEL_MK_LO;
        else if (paddr == ADDR_W'(OFS_MK_HI)) sel = SEL_MK_HI;
        else if (paddr == ADDR_W'(OFS_ST_LO)) sel = SEL_ST_LO;
        else if (paddr == ADDR_W'(OFS_ST_HI)) sel = SEL_ST_HI;
        else                                  sel = SEL_NONE;
    end

    ictl_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .pclk    (pclk),
        .presetn (presetn),
        .wr_en   (xfer && pwrite),
        .sel     (sel),
        .wdata   (pwdata),
        .en_w    (en_w),
        .mk_w    (mk_w)
    );

    ictl_status #(.NUM_SRC(NUM_SRC)) u_stat (
        .pclk    (pclk),
        .presetn (presetn),
        .src     (irq_src),
        .en_w    (en_w),
        .mk_w    (mk_w),
        .fstat_w (fstat_w),
        .irq     (irq_out)
    );

    // read data mux, live only in a read access cycle
    always_comb begin
        prdata = '0;
        if (xfer && !pwrite) begin
            unique case (sel)
                SEL_EN_LO: prdata = en_w[31:0];
                SEL_EN_HI: prdata = en_w[63:32];
                SEL_MK_LO: prdata = mk_w[31:0];
                SEL_MK_HI: prdata = mk_w[63:32];
                SEL_ST_LO: prdata = fstat_w[31:0];
                SEL_ST_HI: prdata = fstat_w[63:32];
                default:   prdata = '0;
            endcase
        end
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

endmodule

// File: rtl/apb_irq_ctrl_chk.sv
module apb_irq_ctrl_chk
    import ictl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic              irq_out,
    input logic [63:0]       fstat,
    input logic [63:0]       en_w,
    input logic [63:0]       mk_w
);

    // R5
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fstat) |=> irq_out);

    // R5
    irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|fstat) |=> !irq_out);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !psel |=> ($stable(en_w) && $stable(mk_w)));

    // R6
    ro_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite &&
         (paddr == ADDR_W'(OFS_ST_LO) || paddr == ADDR_W'(OFS_ST_HI)))
        |=> ($stable(en_w) && $stable(mk_w)));

    // R7
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite &&
         paddr != ADDR_W'(OFS_EN_LO) && paddr != ADDR_W'(OFS_EN_HI) &&
         paddr != ADDR_W'(OFS_MK_LO) && paddr != ADDR_W'(OFS_MK_HI))
        |=> ($stable(en_w) && $stable(mk_w)));

endmodule

bind apb_irq_ctrl apb_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (pclk),
    .rst_n   (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .irq_out (irq_out),
    .fstat   (fstat_w),
    .en_w    (en_w),
    .mk_w    (mk_w)
);

// File: tb/sim_apb_irq_ctrl.sv
`timescale 1ns/1ps
module sim_apb_irq_ctrl;

    localparam int N  = 40;
    localparam int AW = 8;
    localparam logic [31:0] LO_ALL = (N >= 32) ? 32'hFFFF_FFFF : 32'((64'd1 << N) - 1);
    localparam logic [31:0] HI_ALL = (N > 32) ? 32'((64'd1 << (N - 32)) - 1) : 32'd0;

    logic          clk = 1'b0;
    logic          presetn = 1'b0;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          pready;
    logic          pslverr;
    logic [N-1:0]  src = '0;
    logic          irq_out;

    int vecs = 0;
    int bad  = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    apb_irq_ctrl #(.NUM_SRC(N), .ADDR_W(AW)) u0 (
        .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq_src(src), .irq_out(irq_out)
    );

    // behavioural reference model
    logic [63:0] m_en = '0, m_mk = '0, m_srcq = '0;
    logic        m_irq = 1'b0, m_setup = 1'b0;

    always @(posedge clk) begin
        if (!presetn) begin
            m_en <= '0; m_mk <= '0; m_srcq <= '0; m_irq <= 1'b0; m_setup <= 1'b0;
        end else begin
            logic [63:0] ne, nm;
            ne = m_en; nm = m_mk;
            if (m_setup && psel && penable && pwrite) begin
                for (int i = 0; i < N; i++) begin
                    if (i < 32 && paddr == 8'h00) ne[i] = pwdata[i];
                    if (i >= 32 && paddr == 8'h04) ne[i] = pwdata[i - 32];
                    if (i < 32 && paddr == 8'h08) nm[i] = pwdata[i];
                    if (i >= 32 && paddr == 8'h0C) nm[i] = pwdata[i - 32];
                end
            end
            m_irq   <= (m_srcq & m_en & ~m_mk) != 0;
            m_en    <= ne;
            m_mk    <= nm;
            m_srcq  <= 64'(src);
            m_setup <= psel && !penable;
        end
    end

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        logic [63:0] fs;
        fs = m_srcq & m_en & ~m_mk;
        case (a)
            8'h00: return m_en[31:0];
            8'h04: return m_en[63:32];
            8'h08: return m_mk[31:0];
            8'h0C: return m_mk[63:32];
            8'h30: return fs[31:0];
            8'h34: return fs[63:32];
            default: return 32'd0;
        endcase
    endfunction

    // per-clock comparison: R5, R8, R10
    always @(negedge clk) begin
        if (presetn && !done) begin
            vecs++;
            if (irq_out !== m_irq) begin
                bad++;
                $display("FAIL R5 irq_out act=%b exp=%b t=%0t", irq_out, m_irq, $time);
            end
            if (pready !== 1'b1 || pslverr !== 1'b0) begin
                bad++;
                $display("FAIL R8 pready/pslverr act=%b/%b exp=1/0", pready, pslverr);
            end
            if (!(psel && penable && !pwrite) && prdata !== 32'd0) begin
                bad++;
                $display("FAIL R10 idle prdata act=%h exp=0", prdata);
            end
        end
    end

    task automatic apb_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd_lit(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1; #1;
        vecs++;
        if (prdata !== exp) begin
            bad++;
            $display("FAIL %s addr=%h act=%h exp=%h", tag, a, prdata, exp);
        end
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic rd_mdl(input logic [AW-1:0] a, input string tag);
        logic [31:0] exp;
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1; #1;
        exp = model_read(a);
        vecs++;
        if (prdata !== exp) begin
            bad++;
            $display("FAIL %s addr=%h act=%h exp=%h", tag, a, prdata, exp);
        end
        @(negedge clk); psel = 0; penable = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL R1-watchdog: run hung act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        presetn = 1'b1;
        // R1 reset state
        rd_lit(8'h00, 32'd0, "R1 en lo");
        rd_lit(8'h0C, 32'd0, "R1 mk hi");
        rd_lit(8'h30, 32'd0, "R1 status lo");
        // R2 trimming
        apb_wr(8'h00, 32'hFFFF_FFFF);
        apb_wr(8'h04, 32'hFFFF_FFFF);
        rd_lit(8'h00, LO_ALL, "R2 en lo");
        rd_lit(8'h04, HI_ALL, "R2 en hi");
        apb_wr(8'h08, 32'hFFFF_FFFF);
        apb_wr(8'h0C, 32'hFFFF_FFFF);
        rd_lit(8'h0C, HI_ALL, "R2 mk hi");
        // R3 all masked: sources present but no status
        src = 40'hA5_0000_0003;
        repeat (3) @(negedge clk);
        rd_lit(8'h30, 32'd0, "R3 masked status lo");
        apb_wr(8'h08, 32'd0);
        apb_wr(8'h0C, 32'd0);
        // R4 packing
        rd_lit(8'h30, 32'h0000_0003, "R4 status lo");
        rd_lit(8'h34, 32'h0000_00A5, "R4 status hi");
        // R3 mask one bit
        apb_wr(8'h08, 32'h0000_0001);
        rd_lit(8'h30, 32'h0000_0002, "R3 mask bit0");
        // R6 status write ignored
        apb_wr(8'h30, 32'd0);
        apb_wr(8'h34, 32'd0);
        rd_lit(8'h30, 32'h0000_0002, "R6 status lo after write");
        rd_lit(8'h00, LO_ALL, "R6 en lo untouched");
        // R7 unmapped
        apb_wr(8'h10, 32'd0);
        apb_wr(8'h31, 32'd0);
        rd_lit(8'h10, 32'd0, "R7 unmapped read");
        rd_lit(8'h00, LO_ALL, "R7 en lo untouched");
        // R9 access without setup ignored
        @(negedge clk); psel = 1; penable = 1; pwrite = 1; paddr = 8'h00; pwdata = 32'd0;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
        rd_lit(8'h00, LO_ALL, "R9 no-setup write ignored");
        // R4 level: sources drop
        src = '0;
        repeat (3) @(negedge clk);
        rd_lit(8'h34, 32'd0, "R4 level clear");
        // coincidence: enable write and source rise on the same edge
        apb_wr(8'h00, 32'd0);
        fork
            apb_wr(8'h00, 32'h0000_0004);
            begin @(negedge clk); @(negedge clk); src[2] = 1'b1; end
        join
        rd_mdl(8'h30, "R4 coincident enable");
        // coincidence: mask write lands as the source drops
        fork
            apb_wr(8'h08, 32'h0000_0004);
            begin @(negedge clk); @(negedge clk); src[2] = 1'b0; end
        join
        rd_mdl(8'h30, "R3 coincident mask");
        // back-to-back setup after access
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 8'h08; pwdata = 32'd0;
        @(negedge clk); penable = 1;
        @(negedge clk); penable = 0; pwrite = 0; paddr = 8'h08;
        @(negedge clk); penable = 1; #1;
        vecs++;
        if (prdata !== 32'd0) begin
            bad++;
            $display("FAIL R9 back-to-back act=%h exp=0", prdata);
        end
        @(negedge clk); psel = 0; penable = 0;
        src = 40'h80_0000_0000;
        repeat (4) @(negedge clk);
        rd_mdl(8'h34, "R4 top source");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule